// File: doc/BRIEF.md
# Boundary-Scan Wrapper with Signature and Pattern Modes

This block is the test logic that sits around the I/O boundary of an 8-bit transceiver core. A four-wire serial test port drives it: `tck` clocks it, `tms` steers it, `tdi` carries data in and `tdo` carries data out. A 16-state controller runs the port. The controller selects one of three serial paths: an 8-bit instruction register, a one-bit bypass stage, or a data register chosen by the current instruction. `tdo` changes only on falling edges of `tck`, and its enable is asserted only while a path is shifting.

The boundary register has one cell per device pin. It serves two plain instructions. The first takes a snapshot of the pins while the core keeps running. The second takes over the core-facing inputs and the pad-facing outputs. Two more instructions switch to an 8-bit linear feedback register. In the signature mode this register folds the input pins into a running signature. In the pattern mode it drives a pseudo-random sequence onto the output pins. The register steps once on each `tck` edge spent in Run-Test/Idle. It is seeded, and later read back, through an ordinary data-register scan. A capture followed by a scan in the takeover mode reads back the values the cells are driving, which gives a self-test of the boundary cells.

`por_n` is a power-on reset. It puts the controller in Test-Logic-Reset and the instruction in bypass.

Top module: `bscan_wrap`

## Requirements
- R1: Five consecutive rising `tck` edges with `tms` high put the controller in Test-Logic-Reset from any state. That state loads instruction 0xFF (bypass) and restores the normal pin paths.
- R2: An instruction scan shifts 8 bits, least significant bit first. During Capture-IR the instruction shift stage loads 0x01. The shifted code becomes active on the rising edge that leaves Update-IR.
- R3: `tdo_en` is high only while the controller is in Shift-IR or Shift-DR. `tdo` changes only on falling `tck` edges.
- R4: Under bypass, the data path is a single stage that captures 0, so TDI reappears at TDO one shift later. Every code other than 0x00, 0x01, 0x0B, 0x0C and 0xFF behaves as bypass.
- R5: Code 0x01 (snapshot) captures the pins during Capture-DR and leaves `pin_out = func_out` and `core_in = pin_in` undisturbed.
- R6: Code 0x00 (takeover) drives `pin_out` from the output cells and `core_in` from the input cells. Both are loaded at Update-DR, and `func_out` and `pin_in` have no effect on them. A capture returns the driven `pin_out` value.
- R7: The boundary chain is 16 bits long. The first bit out at TDO is `pin_in[0]`; chain bit k holds `pin_in[k]` for k<8 and `pin_out[k-8]` for k≥8. TDI enters at bit 15.
- R8: Code 0x0B (signature) replaces the register value s with step(s) XOR `pin_in` on every rising `tck` edge taken in Run-Test/Idle, including the edge that leaves it.
- R9: Code 0x0C (pattern) replaces s with step(s) on those same edges and drives `pin_out = s`. step shifts s left by one and sets the new bit 0 to s[7]^s[5]^s[4]^s[3], which is the polynomial x^8+x^6+x^5+x^4+1 with period 255.
- R10: Under 0x0B or 0x0C the data path is 8 bits long. Capture-DR reads the register value, Update-DR loads the shifted value into the register, and the register holds in every other state.
- R11: Under bypass, snapshot or any unlisted code, and while `por_n` is low, `pin_out = func_out` and `core_in = pin_in`, with no clock needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| por_n | input | 1 | Power-on reset, active low |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Serial test data in |
| tdo | output | 1 | Serial test data out, updated on falling `tck` |
| tdo_en | output | 1 | Output enable for `tdo` (low means high impedance) |
| pin_in | input | 8 | Values arriving at the device input pins |
| func_out | input | 8 | Values the core wants driven to the output pins |
| core_in | output | 8 | Input values presented to the core |
| pin_out | output | 8 | Values driven to the output pads |

## Verification
Every TAP move in the bench is one `tck` period. Inputs are set one time unit after a falling edge. `tdo` and `tdo_en` are read at that same instant, because they were registered on that falling edge, and the read bit is the one the next rising edge shifts out. The pin outputs are sampled one time unit after the rising edge that enters Run-Test/Idle. An updated latch therefore appears right after the Update-DR exit edge, and the register value seen there has not yet stepped. The expected signature and pattern values step once for each rising edge spent in Run-Test/Idle, and this count includes the first edge of the next scan, so the value read back is the register after exactly that many steps.

// File: rtl/bscan_pkg.sv
package bscan_pkg;

  localparam int unsigned IR_W = 8;

  localparam logic [IR_W-1:0] OP_EXTEST = 8'h00;
  localparam logic [IR_W-1:0] OP_SAMPLE = 8'h01;
  localparam logic [IR_W-1:0] OP_PSA    = 8'h0B;
  localparam logic [IR_W-1:0] OP_PRPG   = 8'h0C;
  localparam logic [IR_W-1:0] OP_BYPASS = 8'hFF;
  localparam logic [IR_W-1:0] IR_CAPTURE = 8'h01;

  typedef enum logic [3:0] {
    ST_TLR, ST_RTI,
    ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PA_DR, ST_EX2_DR, ST_UPD_DR,
    ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PA_IR, ST_EX2_IR, ST_UPD_IR
  } tap_state_e;

  typedef enum logic [2:0] {
    M_BYPASS, M_SAMPLE, M_EXTEST, M_PSA, M_PRPG
  } mode_e;

  function automatic tap_state_e tap_next(input tap_state_e s, input logic tms);
    tap_state_e n;
    unique case (s)
      ST_TLR:    n = tms ? ST_TLR    : ST_RTI;
      ST_RTI:    n = tms ? ST_SEL_DR : ST_RTI;
      ST_SEL_DR: n = tms ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: n = tms ? ST_EX1_DR : ST_SH_DR;
      ST_SH_DR:  n = tms ? ST_EX1_DR : ST_SH_DR;
      ST_EX1_DR: n = tms ? ST_UPD_DR : ST_PA_DR;
      ST_PA_DR:  n = tms ? ST_EX2_DR : ST_PA_DR;
      ST_EX2_DR: n = tms ? ST_UPD_DR : ST_SH_DR;
      ST_UPD_DR: n = tms ? ST_SEL_DR : ST_RTI;
      ST_SEL_IR: n = tms ? ST_TLR    : ST_CAP_IR;
      ST_CAP_IR: n = tms ? ST_EX1_IR : ST_SH_IR;
      ST_SH_IR:  n = tms ? ST_EX1_IR : ST_SH_IR;
      ST_EX1_IR: n = tms ? ST_UPD_IR : ST_PA_IR;
      ST_PA_IR:  n = tms ? ST_EX2_IR : ST_PA_IR;
      ST_EX2_IR: n = tms ? ST_UPD_IR : ST_SH_IR;
      ST_UPD_IR: n = tms ? ST_SEL_DR : ST_RTI;
      default:   n = ST_TLR;
    endcase
    return n;
  endfunction

  function automatic mode_e decode_op(input logic [IR_W-1:0] op);
    mode_e m;
    unique case (op)
      OP_EXTEST: m = M_EXTEST;
      OP_SAMPLE: m = M_SAMPLE;
      OP_PSA:    m = M_PSA;
      OP_PRPG:   m = M_PRPG;
      default:   m = M_BYPASS;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
  import bscan_pkg::*;
(
  input  logic       tck,
  input  logic       por_n,
  input  logic       tms,
  output tap_state_e state
);

  always_ff @(posedge tck or negedge por_n) begin
    if (!por_n) state <= ST_TLR;
    else        state <= tap_next(state, tms);
  end

endmodule

// File: rtl/instr_reg.sv
module instr_reg
  import bscan_pkg::*;
(
  input  logic            tck,
  input  logic            por_n,
  input  tap_state_e      state,
  input  logic            tdi,
  output logic [IR_W-1:0] ir,
  output logic            ir_so
);

  logic [IR_W-1:0] sh;

  always_ff @(posedge tck or negedge por_n) begin
    if (!por_n) begin
      sh <= '1;
      ir <= OP_BYPASS;
    end else begin
      if (state == ST_TLR)         ir <= OP_BYPASS;
      else if (state == ST_UPD_IR) ir <= sh;
      if (state == ST_CAP_IR)      sh <= IR_CAPTURE;
      else if (state == ST_SH_IR)  sh <= {tdi, sh[IR_W-1:1]};
    end
  end

  assign ir_so = sh[0];

endmodule

// File: rtl/bound_reg.sv
module bound_reg #(
  parameter int unsigned PIN_W = 8
) (
  input  logic             tck,
  input  logic             por_n,
  input  logic             cap,
  input  logic             shift,
  input  logic             upd,
  input  logic             tdi,
  input  logic [PIN_W-1:0] pin_in,
  input  logic [PIN_W-1:0] pin_obs,
  output logic             so,
  output logic [PIN_W-1:0] hold_in,
  output logic [PIN_W-1:0] hold_out
);

  localparam int unsigned N = 2 * PIN_W;

  logic [N-1:0] cap_v, chain, ser, hold;

  assign cap_v = {pin_obs, pin_in};
  assign ser   = {tdi, chain[N-1:1]};

  for (genvar k = 0; k < N; k++) begin : g_cell
    logic q, l;
    always_ff @(posedge tck or negedge por_n) begin
      if (!por_n) begin
        q <= 1'b0;
        l <= 1'b0;
      end else begin
        if (cap)        q <= cap_v[k];
        else if (shift) q <= ser[k];
        if (upd)        l <= q;
      end
    end
    assign chain[k] = q;
    assign hold[k]  = l;
  end

  assign so       = chain[0];
  assign hold_in  = hold[PIN_W-1:0];
  assign hold_out = hold[N-1:PIN_W];

endmodule

// File: rtl/sig_lfsr.sv
module sig_lfsr #(
  parameter int unsigned     W    = 8,
  parameter logic [W-1:0]    TAPS = W'(8'hB8)
) (
  input  logic         tck,
  input  logic         por_n,
  input  logic         advance,
  input  logic         fold_in,
  input  logic [W-1:0] pin_in,
  input  logic         cap,
  input  logic         shift,
  input  logic         upd,
  input  logic         tdi,
  output logic [W-1:0] sig,
  output logic         so
);

  function automatic logic [W-1:0] step(input logic [W-1:0] s);
    return {s[W-2:0], ^(s & TAPS)};
  endfunction

  logic [W-1:0] sh, sig_nx;

  assign sig_nx = step(sig) ^ (fold_in ? pin_in : '0);

  always_ff @(posedge tck or negedge por_n) begin
    if (!por_n) begin
      sig <= '0;
      sh  <= '0;
    end else begin
      if (upd)          sig <= sh;
      else if (advance) sig <= sig_nx;
      if (cap)          sh  <= sig;
      else if (shift)   sh  <= {tdi, sh[W-1:1]};
    end
  end

  assign so = sh[0];

endmodule

// File: rtl/bscan_wrap.sv
module bscan_wrap
  import bscan_pkg::*;
#(
  parameter int unsigned         PIN_W     = 8,
  parameter logic [PIN_W-1:0]    LFSR_TAPS = PIN_W'(8'hB8)
) (
  input  logic             tck,
  input  logic             por_n,
  input  logic             tms,
  input  logic             tdi,
  output logic             tdo,
  output logic             tdo_en,
  input  logic [PIN_W-1:0] pin_in,
  input  logic [PIN_W-1:0] func_out,
  output logic [PIN_W-1:0] core_in,
  output logic [PIN_W-1:0] pin_out
);

  tap_state_e      state;
  logic [IR_W-1:0] ir;
  logic            ir_so;
  mode_e           mode;

  tap_fsm u_fsm (.tck(tck), .por_n(por_n), .tms(tms), .state(state));

  instr_reg u_ir (
    .tck(tck), .por_n(por_n), .state(state), .tdi(tdi), .ir(ir), .ir_so(ir_so)
  );

  assign mode = decode_op(ir);

  logic dr_cap, dr_sh, dr_upd, in_shift;
  logic sel_bnd, sel_sig, sel_byp, test_mode, sig_adv;

  assign dr_cap    = (state == ST_CAP_DR);
  assign dr_sh     = (state == ST_SH_DR);
  assign dr_upd    = (state == ST_UPD_DR);
  assign in_shift  = (state == ST_SH_DR) || (state == ST_SH_IR);
  assign sel_bnd   = (mode == M_SAMPLE) || (mode == M_EXTEST);
  assign sel_sig   = (mode == M_PSA) || (mode == M_PRPG);
  assign sel_byp   = !sel_bnd && !sel_sig;
  assign test_mode = (mode == M_EXTEST) || sel_sig;
  assign sig_adv   = (state == ST_RTI) && sel_sig;

  logic             bnd_so;
  logic [PIN_W-1:0] hold_in, hold_out;

  bound_reg #(.PIN_W(PIN_W)) u_bnd (
    .tck(tck), .por_n(por_n),
    .cap(dr_cap && sel_bnd), .shift(dr_sh && sel_bnd), .upd(dr_upd && sel_bnd),
    .tdi(tdi), .pin_in(pin_in), .pin_obs(pin_out),
    .so(bnd_so), .hold_in(hold_in), .hold_out(hold_out)
  );

  logic             sig_so;
  logic [PIN_W-1:0] sig;

  sig_lfsr #(.W(PIN_W), .TAPS(LFSR_TAPS)) u_sig (
    .tck(tck), .por_n(por_n), .advance(sig_adv), .fold_in(mode == M_PSA),
    .pin_in(pin_in),
    .cap(dr_cap && sel_sig), .shift(dr_sh && sel_sig), .upd(dr_upd && sel_sig),
    .tdi(tdi), .sig(sig), .so(sig_so)
  );

  logic byp;

  always_ff @(posedge tck or negedge por_n) begin
    if (!por_n)                 byp <= 1'b0;
    else if (dr_cap && sel_byp) byp <= 1'b0;
    else if (dr_sh && sel_byp)  byp <= tdi;
  end

  logic dr_bit;

  always_comb begin
    if (sel_bnd)      dr_bit = bnd_so;
    else if (sel_sig) dr_bit = sig_so;
    else              dr_bit = byp;
  end

  always_ff @(negedge tck or negedge por_n) begin
    if (!por_n) begin
      tdo    <= 1'b0;
      tdo_en <= 1'b0;
    end else begin
      tdo_en <= in_shift;
      tdo    <= (state == ST_SH_IR) ? ir_so : dr_bit;
    end
  end

  always_comb begin
    if (mode == M_PRPG) pin_out = sig;
    else if (test_mode) pin_out = hold_out;
    else                pin_out = func_out;
    core_in = test_mode ? hold_in : pin_in;
  end

endmodule

// File: rtl/bscan_wrap_chk.sv
module bscan_wrap_chk
  import bscan_pkg::*;
#(
  parameter int unsigned      PIN_W = 8,
  parameter logic [PIN_W-1:0] TAPS  = PIN_W'(8'hB8)
) (
  input logic             tck,
  input logic             por_n,
  input logic             tms,
  input logic             tdo_en,
  input tap_state_e       state,
  input logic [IR_W-1:0]  ir,
  input mode_e            mode,
  input logic [PIN_W-1:0] sig,
  input logic [PIN_W-1:0] pin_in,
  input logic [PIN_W-1:0] func_out,
  input logic [PIN_W-1:0] core_in,
  input logic [PIN_W-1:0] pin_out
);

  function automatic logic [PIN_W-1:0] ref_step(input logic [PIN_W-1:0] s);
    logic fb;
    fb = 1'b0;
    for (int i = 0; i < int'(PIN_W); i++) begin
      if (TAPS[i]) fb = fb ^ s[i];
    end
    return {s[PIN_W-2:0], fb};
  endfunction

  logic [2:0] ones;

  always_ff @(posedge tck or negedge por_n) begin
    if (!por_n)             ones <= '0;
    else if (!tms)          ones <= '0;
    else if (ones != 3'd5)  ones <= ones + 3'd1;
  end

  AST_FIVE_ONES_TLR: assert property (@(posedge tck) disable iff (!por_n)
    (ones == 3'd5) |-> (state == ST_TLR)); // R1
  AST_TLR_BYPASS: assert property (@(posedge tck) disable iff (!por_n)
    (state == ST_TLR) |=> (ir == OP_BYPASS)); // R1
  AST_TDO_WINDOW: assert property (@(posedge tck) disable iff (!por_n)
    tdo_en |-> (state == ST_SH_DR || state == ST_SH_IR)); // R3
  AST_PSA_FOLD: assert property (@(posedge tck) disable iff (!por_n)
    (state == ST_RTI && mode == M_PSA) |=> (sig == (ref_step($past(sig)) ^ $past(pin_in)))); // R8
  AST_PRPG_STEP: assert property (@(posedge tck) disable iff (!por_n)
    (state == ST_RTI && mode == M_PRPG) |=> (sig == ref_step($past(sig)))); // R9
  AST_PRPG_DRIVE: assert property (@(posedge tck) disable iff (!por_n)
    (mode == M_PRPG) |-> (pin_out == sig)); // R9
  AST_SIG_HOLD: assert property (@(posedge tck) disable iff (!por_n)
    (state != ST_RTI && state != ST_UPD_DR) |=> $stable(sig)); // R10
  AST_NORMAL_PASS: assert property (@(posedge tck) disable iff (!por_n)
    (mode == M_BYPASS || mode == M_SAMPLE) |-> (pin_out == func_out && core_in == pin_in)); // R11

endmodule

bind bscan_wrap bscan_wrap_chk #(.PIN_W(PIN_W), .TAPS(LFSR_TAPS)) u_chk (
  .tck(tck), .por_n(por_n), .tms(tms), .tdo_en(tdo_en), .state(state), .ir(ir),
  .mode(mode), .sig(sig), .pin_in(pin_in), .func_out(func_out),
  .core_in(core_in), .pin_out(pin_out)
);

// File: tb/test_bscan_wrap.sv
module test_bscan_wrap;

  localparam int W = 8;

  logic tck = 1'b0;
  logic por_n = 1'b0;
  logic tms = 1'b1;
  logic tdi = 1'b0;
  logic [W-1:0] pin_in = '0;
  logic [W-1:0] func_out = '0;
  logic tdo, tdo_en;
  logic [W-1:0] core_in, pin_out;

  int n_chk = 0;
  int n_fail = 0;
  int en_bad = 0;
  int edge_bad = 0;
  logic last_en;

  always #2 tck = ~tck;

  bscan_wrap i_bscan_wrap (
    .tck(tck), .por_n(por_n), .tms(tms), .tdi(tdi), .tdo(tdo), .tdo_en(tdo_en),
    .pin_in(pin_in), .func_out(func_out), .core_in(core_in), .pin_out(pin_out)
  );

  function automatic logic [7:0] nx(input logic [7:0] s, input logic [7:0] x);
    return {s[6:0], s[7] ^ s[5] ^ s[4] ^ s[3]} ^ x;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input logic m, input logic d, output logic q);
    @(negedge tck);
    #1;
    tms = m;
    tdi = d;
    q = tdo;
    last_en = tdo_en;
    @(posedge tck);
    #1;
  endtask

  task automatic shift_bits(input int n, input logic [31:0] din, output logic [31:0] dout);
    logic q;
    dout = '0;
    for (int i = 0; i < n; i++) begin
      step(i == n - 1, din[i], q);
      dout[i] = q;
      if (!last_en) en_bad++;
      if (tdo !== q) edge_bad++;
    end
  endtask

  task automatic scan_dr(input int n, input logic [31:0] din, output logic [31:0] dout);
    logic q;
    step(1'b1, 1'b0, q);
    step(1'b0, 1'b0, q);
    step(1'b0, 1'b0, q);
    shift_bits(n, din, dout);
    step(1'b1, 1'b0, q);
    step(1'b0, 1'b0, q);
  endtask

  task automatic scan_ir(input logic [7:0] op, output logic [7:0] cap);
    logic q;
    logic [31:0] r;
    step(1'b1, 1'b0, q);
    step(1'b1, 1'b0, q);
    step(1'b0, 1'b0, q);
    step(1'b0, 1'b0, q);
    shift_bits(8, {24'h0, op}, r);
    cap = r[7:0];
    step(1'b1, 1'b0, q);
    step(1'b0, 1'b0, q);
  endtask

  task automatic tap_reset();
    logic q;
    for (int i = 0; i < 5; i++) step(1'b1, 1'b0, q);
    step(1'b0, 1'b0, q);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    #(4 * 100000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
    $finish;
  end

  initial begin
    logic q;
    logic [31:0] r;
    logic [7:0] c8, m, o, i8, po;

    pin_in = 8'h3C;
    func_out = 8'hA5;
    #5;
    check("R11 reset pass-through", {16'h0, pin_out, core_in}, {16'h0, 8'hA5, 8'h3C});
    check("R3 reset tdo_en", {31'h0, tdo_en}, 32'h0);
    @(negedge tck);
    por_n = 1'b1;
    tap_reset();
    step(1'b0, 1'b0, q);
    check("R3 idle tdo_en low", {31'h0, last_en}, 32'h0);

    // R2: capture pattern of the instruction scan, then snapshot mode
    scan_ir(8'h01, c8);
    check("R2 ir capture", {24'h0, c8}, 32'h01);

    // R5 / R7 snapshot sweep
    for (int v = 0; v < 16; v++) begin
      pin_in = 8'(v * 37 + 5);
      func_out = 8'(v * 91) ^ 8'h6E;
      scan_dr(16, 32'h0, r);
      check("R5 snapshot capture", {16'h0, r[15:0]}, {16'h0, func_out, pin_in});
      check("R11 snapshot pass-through", {16'h0, pin_out, core_in}, {16'h0, func_out, pin_in});
    end
    scan_dr(24, 32'h0000_005A, r);
    check("R7 chain length", {24'h0, r[23:16]}, 32'h5A);
    check("R7 chain order", {16'h0, r[15:0]}, {16'h0, func_out, pin_in});

    // R6 takeover with loop-back capture
    scan_ir(8'h00, c8);
    po = 8'h00;
    for (int v = 0; v < 8; v++) begin
      o = 8'(v * 53 + 1);
      i8 = ~8'(v * 19);
      scan_dr(16, {16'h0, o, i8}, r);
      if (v > 0) check("R6 capture of driven outputs", {16'h0, r[15:0]}, {16'h0, po, pin_in});
      check("R6 outputs from cells", {16'h0, pin_out, core_in}, {16'h0, o, i8});
      func_out = ~func_out;
      pin_in = pin_in + 8'd7;
      #1;
      check("R6 core inputs ignored", {16'h0, pin_out, core_in}, {16'h0, o, i8});
      po = o;
    end
    check("R3 tdo_en during shifts", en_bad, 0);
    check("R3 tdo stable after rising edge", edge_bad, 0);

    // R4 near-exhaustive code sweep
    for (int c = 0; c < 256; c++) begin
      if (c == 8'h00 || c == 8'h01 || c == 8'h0B || c == 8'h0C) continue;
      scan_ir(8'(c), c8);
      scan_dr(9, {24'h0, 8'(c) ^ 8'h5D}, r);
      check("R4 one-stage path", {23'h0, r[8:0]}, {23'h0, 8'(c) ^ 8'h5D, 1'b0});
      if (c[3:0] == 4'h7) check("R11 bypass pass-through", {16'h0, pin_out, core_in}, {16'h0, func_out, pin_in});
    end

    // R1 escape from Shift-DR with five TMS-high edges
    scan_ir(8'h00, c8);
    scan_dr(16, 32'h0000_F00F, r);
    check("R6 takeover drive", {24'h0, pin_out}, 32'hF0);
    step(1'b1, 1'b0, q);
    step(1'b0, 1'b0, q);
    step(1'b0, 1'b0, q);
    tap_reset();
    check("R1 pins restored", {16'h0, pin_out, core_in}, {16'h0, func_out, pin_in});
    scan_dr(9, 32'h96, r);
    check("R1 bypass after reset", {23'h0, r[8:0]}, {23'h0, 8'h96, 1'b0});

    // R9 / R10 pattern mode
    scan_ir(8'h0C, c8);
    for (int s = 0; s < 6; s++) begin
      m = 8'(s * 45 + 1);
      scan_dr(8, {24'h0, m}, r);
      check("R10 seed load", {24'h0, pin_out}, {24'h0, m});
      for (int k = 0; k < s + 2; k++) begin
        step(1'b0, 1'b0, q);
        m = nx(m, 8'h00);
        check("R9 pattern step", {24'h0, pin_out}, {24'h0, m});
      end
      scan_dr(8, 32'h0, r);
      m = nx(m, 8'h00);
      check("R10 pattern readback", {24'h0, r[7:0]}, {24'h0, m});
    end
    scan_dr(8, 32'h01, r);
    for (int k = 0; k < 254; k++) step(1'b0, 1'b0, q);
    scan_dr(8, 32'h0, r);
    check("R9 period 255", {24'h0, r[7:0]}, 32'h01);

    // R8 signature mode
    scan_ir(8'h0B, c8);
    for (int s = 0; s < 6; s++) begin
      m = 8'(s * 29 + 7);
      scan_dr(8, {24'h0, m}, r);
      for (int j = 0; j < s + 4; j++) begin
        pin_in = 8'(j * 13) ^ 8'(s * 71);
        step(1'b0, 1'b0, q);
        m = nx(m, pin_in);
      end
      pin_in = 8'h5A;
      scan_dr(8, 32'h0, r);
      m = nx(m, 8'h5A);
      check("R8 signature", {24'h0, r[7:0]}, {24'h0, m});
    end

    summary();
    $finish;
  end

endmodule